// File: doc/BRIEF.md
# Quad-Rate Burst-of-Four Synchronous SRAM Core

This block is a synthesizable model of a separate-I/O synchronous SRAM that has one read port and one write port, each moving a burst of four 18-bit words. Each burst takes two command-clock cycles and moves one word per clock edge. The command clock is modelled through a single beat clock `clk` that runs at twice its rate. An internal phase register marks every second beat edge as a command-clock rising edge. Only there are the active-low read and write selects and the shared group address sampled.

The external address picks a group of four words. A 2-bit internal counter supplies the low two bits of the word address, stepping 0, 1, 2, 3 from the base of the group. The read machine and the write machine are independent and may start in the same command cycle. Write words are committed to the array one beat at a time, under two active-low lane enables. Read words leave the block 1.5 command cycles after the command and are marked by a valid flag. An echo strobe follows the command-clock phase so that the receiver can frame the output words. When a read fetches a word at the same edge that the write side commits it, the read returns the new data.

Top module: `qdr_b4_sram`

## Requirements
- R1: While `rst` is high, at every beat edge `q_valid` and `echo` go to 0 and `dout` goes to all zeros.
- R2: `echo` is 1 after each command-clock rising edge and 0 after each of the other beat edges. The first beat edge after reset is released is a command-clock rising edge, and from then on every second beat edge is one.
- R3: `rd_n` and `wr_n` are active low and take effect only at command-clock rising edges. A low level at any other beat edge has no effect, and a high level means no operation.
- R4: A write accepted at edge E with group G writes word address 4*G+k, for k = 0..3, with the `din` and `bw_n` sampled at edge E+k.
- R5: `bw_n[0]` low enables bits 8:0 of the word being written and `bw_n[1]` low enables bits 17:9. A lane whose enable is high keeps its previous contents.
- R6: A read accepted at edge E with group G drives `q_valid` high and `dout` equal to word 4*G+k after edge E+3+k, for k = 0..3. When `q_valid` is low, `dout` is zero.
- R7: While its own burst is running, a machine ignores a command at the command-clock rising edge E+2. It accepts a new command at E+4.
- R8: A read and a write accepted at the same edge are both carried out, each to its own group.
- R9: The read word for offset k holds the array contents as they stand after edge E+2+k, including a write to that same word at that edge. A same-group write that starts at E or at E+2 is therefore seen by the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, twice the command-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Read select, active low |
| wr_n | input | 1 | Write select, active low |
| addr | input | GRP_W | Group address shared by read and write |
| din | input | 18 | Write data, one word per beat |
| bw_n | input | 2 | Active-low lane write enables (bits 8:0 and 17:9) |
| dout | output | 18 | Read data, one word per beat |
| q_valid | output | 1 | High on each beat that carries a read word |
| echo | output | 1 | Echo strobe that follows the command-clock phase |

## Verification
The checker checks on every cycle that the echo strobe alternates. It also checks that commands are accepted only on command-clock rising edges and never at the middle edge of a running burst, that valid runs come in multiples of four beats and start four sampled edges after a read is accepted, and that the data bus stays at zero while no word is valid. Only the bench scenarios can show the values in the array. These cover the burst address ordering, lane masking, the fact that ignored commands leave memory unchanged, and the read-during-write cases of a same-group write started in the same command cycle or one command cycle later.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;
  localparam int BURST  = 4;
  localparam int OFF_W  = $clog2(BURST);
endpackage

// File: rtl/qdr_burst_seq.sv
// Burst sequencer: accepts a command at a command-clock rising edge when idle,
// then walks the 2-bit word offset through the rest of the four-beat burst.
module qdr_burst_seq #(
  parameter int GRP_W = 6,
  parameter int OFF_W = 2,
  parameter int BURST = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     k_rise,
  input  logic                     req_n,
  input  logic [GRP_W-1:0]         grp,
  output logic                     accept,
  output logic                     act,
  output logic [GRP_W+OFF_W-1:0]   word
);
  logic             busy;
  logic [OFF_W-1:0] cnt;
  logic [GRP_W-1:0] base;

  assign accept = k_rise && !req_n && !busy;
  assign act    = accept || busy;
  assign word   = accept ? {grp, {OFF_W{1'b0}}} : {base, cnt};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      base <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= OFF_W'(1);
      base <= grp;
    end else if (busy) begin
      cnt <= cnt + OFF_W'(1);
      if (cnt == OFF_W'(BURST - 1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/qdr_lane_ram.sv
// One byte lane of the array: single write port, registered read port,
// new data returned when read and write hit the same word on one edge.
module qdr_lane_ram #(
  parameter int AW = 8,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= (we && (waddr == raddr)) ? wdata : mem[raddr];
  end
endmodule

// File: rtl/qdr_b4_sram.sv
module qdr_b4_sram
  import qdr_pkg::*;
#(
  parameter int GRP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [GRP_W-1:0]  addr,
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  bw_n,
  output logic [DATA_W-1:0] dout,
  output logic              q_valid,
  output logic              echo
);
  localparam int AW = GRP_W + OFF_W;

  logic          ph;
  logic          k_rise;
  logic          wr_acc, wr_act;
  logic          rd_acc, rd_act;
  logic [AW-1:0] wr_word, rd_word;
  logic          s1_v, s2_v, ram_v;
  logic [AW-1:0] s1_a, s2_a;
  logic [DATA_W-1:0] ram_q;

  assign k_rise = !ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= 1'b0;
      echo <= 1'b0;
    end else begin
      ph   <= ~ph;
      echo <= k_rise;
    end
  end

  qdr_burst_seq #(.GRP_W(GRP_W), .OFF_W(OFF_W), .BURST(BURST)) u_wseq (
    .clk(clk), .rst(rst), .k_rise(k_rise), .req_n(wr_n), .grp(addr),
    .accept(wr_acc), .act(wr_act), .word(wr_word)
  );

  qdr_burst_seq #(.GRP_W(GRP_W), .OFF_W(OFF_W), .BURST(BURST)) u_rseq (
    .clk(clk), .rst(rst), .k_rise(k_rise), .req_n(rd_n), .grp(addr),
    .accept(rd_acc), .act(rd_act), .word(rd_word)
  );

  // Read address pipeline: two beats of delay before the array fetch
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v  <= 1'b0;
      s2_v  <= 1'b0;
      ram_v <= 1'b0;
      s1_a  <= '0;
      s2_a  <= '0;
    end else begin
      s1_v  <= rd_act;
      s1_a  <= rd_word;
      s2_v  <= s1_v;
      s2_a  <= s1_a;
      ram_v <= s2_v;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    qdr_lane_ram #(.AW(AW), .W(LANE_W)) u_ram (
      .clk(clk),
      .we(wr_act && !bw_n[l]),
      .waddr(wr_word),
      .wdata(din[l*LANE_W +: LANE_W]),
      .re(s2_v),
      .raddr(s2_a),
      .q(ram_q[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      dout    <= '0;
    end else begin
      q_valid <= ram_v;
      dout    <= ram_v ? ram_q : '0;
    end
  end
endmodule

// File: rtl/qdr_b4_sram_chk.sv
module qdr_b4_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          q_valid,
  input logic [DW-1:0] dout,
  input logic          echo,
  input logic          rd_acc,
  input logic          wr_acc
);
  logic [7:0] vcnt;

  always_ff @(posedge clk) begin
    if (rst) vcnt <= '0;
    else     vcnt <= q_valid ? vcnt + 8'd1 : 8'd0;
  end

  p_echo_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (echo != $past(echo)));

  p_wr_on_krise_r3: assert property (@(posedge clk) disable iff (rst)
    wr_acc |-> !echo);

  p_rd_on_krise_r3: assert property (@(posedge clk) disable iff (rst)
    rd_acc |-> !echo);

  p_burst_len_r6: assert property (@(posedge clk) disable iff (rst)
    (!q_valid && vcnt != 8'd0) |-> (vcnt[1:0] == 2'd0));

  p_valid_latency_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(q_valid) |-> $past(rd_acc, 4));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !q_valid |-> (dout == '0));

  p_wr_mid_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> ##1 !wr_acc);

  p_rd_mid_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> ##1 !rd_acc);
endmodule

bind qdr_b4_sram qdr_b4_sram_chk #(.DW(qdr_pkg::DATA_W)) u_chk (
  .clk(clk), .rst(rst), .q_valid(q_valid), .dout(dout), .echo(echo),
  .rd_acc(rd_acc), .wr_acc(wr_acc)
);

// File: tb/tb_qdr_b4_sram.sv
module tb_qdr_b4_sram;
  localparam int GW    = 6;
  localparam int WORDS = 1 << (GW + 2);
  localparam int NT    = 16;

  // entry: {rd_n, wr_n, group[5:0], bw_n[1:0], seed[17:0]}
  localparam logic [27:0] TBL [NT] = '{
    {1'b1, 1'b0, 6'd1, 2'b00, 18'h10000},
    {1'b1, 1'b1, 6'd0, 2'b00, 18'h10002},
    {1'b1, 1'b0, 6'd2, 2'b00, 18'h20000},
    {1'b1, 1'b1, 6'd0, 2'b00, 18'h20002},
    {1'b1, 1'b0, 6'd3, 2'b00, 18'h30000},
    {1'b1, 1'b1, 6'd0, 2'b00, 18'h30002},
    {1'b0, 1'b1, 6'd1, 2'b11, 18'h00000},
    {1'b1, 1'b1, 6'd0, 2'b11, 18'h00000},
    {1'b0, 1'b1, 6'd2, 2'b11, 18'h00000},
    {1'b1, 1'b1, 6'd0, 2'b11, 18'h00000},
    {1'b0, 1'b0, 6'd4, 2'b00, 18'h04000},
    {1'b1, 1'b1, 6'd0, 2'b00, 18'h04002},
    {1'b0, 1'b1, 6'd4, 2'b11, 18'h00000},
    {1'b1, 1'b1, 6'd0, 2'b11, 18'h00000},
    {1'b0, 1'b1, 6'd3, 2'b11, 18'h00000},
    {1'b1, 1'b1, 6'd0, 2'b11, 18'h00000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_n = 1'b1, wr_n = 1'b1;
  logic [GW-1:0] addr = '0;
  logic [17:0]   din = '0;
  logic [1:0]    bw_n = 2'b11;
  logic [17:0]   dout;
  logic          q_valid, echo;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string tag = "R4";

  // behavioural reference state
  logic [17:0] mm [WORDS];
  bit mph, wb, rb, p1v, p2v, fv, ev, ee;
  int wc, rc, wbs, rbs, p1a, p2a;
  logic [17:0] fd, ed;

  qdr_b4_sram #(.GRP_W(GW)) dut (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .bw_n(bw_n), .dout(dout), .q_valid(q_valid), .echo(echo)
  );

  always #2 clk = ~clk;

  task automatic model_reset();
    mph = 0; wb = 0; rb = 0; p1v = 0; p2v = 0; fv = 0;
    wc = 0; rc = 0; wbs = 0; rbs = 0; p1a = 0; p2a = 0; fd = '0;
  endtask

  task automatic model_step();
    bit kr, wacc, racc, iv;
    int wa, ia;
    kr = !mph; mph = !mph; ee = kr;
    ev = fv; ed = fv ? fd : 18'h0;
    wacc = kr && !wr_n && !wb;
    if (wacc || wb) begin
      wa = wacc ? int'(addr) * 4 : wbs * 4 + wc;
      if (!bw_n[0]) mm[wa][8:0]  = din[8:0];
      if (!bw_n[1]) mm[wa][17:9] = din[17:9];
    end
    if (wacc) begin wb = 1; wc = 1; wbs = int'(addr); end
    else if (wb) begin if (wc == 3) wb = 0; wc = (wc + 1) % 4; end
    racc = kr && !rd_n && !rb;
    iv = racc || rb;
    ia = racc ? int'(addr) * 4 : rbs * 4 + rc;
    if (racc) begin rb = 1; rc = 1; rbs = int'(addr); end
    else if (rb) begin if (rc == 3) rb = 0; rc = (rc + 1) % 4; end
    fv = p2v; fd = mm[p2a];
    p2v = p1v; p2a = p1a;
    p1v = iv;  p1a = ia;
  endtask

  task automatic chk(bit ok, string r, string what, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic beat(bit r, bit w, logic [GW-1:0] a, logic [17:0] d, logic [1:0] b);
    rd_n = r; wr_n = w; addr = a; din = d; bw_n = b;
    @(posedge clk);
    @(negedge clk);
    model_step();
    chk(q_valid === ev, "R6", "q_valid", {17'd0, q_valid}, {17'd0, ev});
    chk(dout === ed, tag, "dout", dout, ed);
    chk(echo === ee, "R2", "echo", {17'd0, echo}, {17'd0, ee});
  endtask

  task automatic kcycle(bit r, bit w, logic [GW-1:0] a, logic [17:0] s, logic [1:0] b);
    beat(r, w, a, s, b);
    beat(1'b1, 1'b1, a, s + 18'd1, b);
  endtask

  task automatic kodd(bit r, bit w, logic [GW-1:0] a);
    beat(1'b1, 1'b1, a, 18'h0, 2'b11);
    beat(r, w, a, 18'h3AAAA, 2'b00);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) kcycle(1'b1, 1'b1, '0, 18'h0, 2'b11);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(q_valid === 1'b0, "R1", "q_valid in reset", {17'd0, q_valid}, 18'd0);
    chk(dout === 18'd0, "R1", "dout in reset", dout, 18'd0);
    chk(echo === 1'b0, "R1", "echo in reset", {17'd0, echo}, 18'd0);
    rst = 1'b0;
    model_reset();

    // R4: table walk of bursts, plus a same-cycle read and write
    tag = "R4";
    for (int i = 0; i < NT; i++)
      kcycle(TBL[i][27], TBL[i][26], TBL[i][25:20], TBL[i][17:0], TBL[i][19:18]);
    idle(3);

    // R5: lane masking over an already written group
    tag = "R5";
    kcycle(1'b1, 1'b0, 6'd1, 18'h3FFFF, 2'b01);
    kcycle(1'b1, 1'b1, 6'd1, 18'h155AA, 2'b10);
    kcycle(1'b0, 1'b1, 6'd1, 18'h0, 2'b11);
    idle(3);

    // R7: commands at the middle edge of a burst are ignored; E+4 accepted
    tag = "R7";
    kcycle(1'b1, 1'b0, 6'd5, 18'h05000, 2'b00);
    kcycle(1'b0, 1'b0, 6'd5, 18'h05002, 2'b00);
    kcycle(1'b1, 1'b0, 6'd6, 18'h06000, 2'b00);
    kcycle(1'b1, 1'b1, 6'd0, 18'h06002, 2'b00);
    kcycle(1'b0, 1'b1, 6'd5, 18'h0, 2'b11);
    idle(1);
    kcycle(1'b0, 1'b1, 6'd6, 18'h0, 2'b11);
    idle(3);

    // R3: selects low only on the other beat edges do nothing
    tag = "R3";
    kodd(1'b0, 1'b0, 6'd5);
    kodd(1'b1, 1'b0, 6'd5);
    kodd(1'b0, 1'b1, 6'd2);
    idle(2);
    kcycle(1'b0, 1'b1, 6'd5, 18'h0, 2'b11);
    idle(3);

    // R8: read and write started in the same command cycle, different groups
    tag = "R8";
    kcycle(1'b0, 1'b0, 6'd7, 18'h07000, 2'b00);
    kcycle(1'b1, 1'b1, 6'd0, 18'h07002, 2'b00);
    idle(3);
    kcycle(1'b0, 1'b1, 6'd7, 18'h0, 2'b11);
    idle(3);

    // R9: read of a group written in the same cycle and one cycle later
    tag = "R9";
    kcycle(1'b1, 1'b0, 6'd8, 18'h08000, 2'b00);
    kcycle(1'b1, 1'b1, 6'd0, 18'h08002, 2'b00);
    kcycle(1'b0, 1'b0, 6'd8, 18'h18000, 2'b00);
    kcycle(1'b1, 1'b1, 6'd0, 18'h18002, 2'b00);
    idle(1);
    kcycle(1'b0, 1'b1, 6'd8, 18'h0, 2'b11);
    kcycle(1'b1, 1'b0, 6'd8, 18'h28000, 2'b00);
    kcycle(1'b1, 1'b1, 6'd0, 18'h28002, 2'b00);
    idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule